// File: doc/BRIEF.md
# Programmable Level Interrupt Priority Controller

This block gathers interrupt causes from peripherals such as timers and turns them into a single request towards a processor core. A one-cycle pulse from a source latches that cause's pending flag. Software can enable each cause on its own, and it gives each cause a level from 0 to 7. Of the causes that are both pending and enabled, the one with the highest level is presented. When two or more share that level, the lowest cause number wins. The request goes out as a request line, a vector number and the winning level.

The controller re-arbitrates on every clock while the request is held. A newly arrived cause with a higher level therefore replaces the one on the outputs, and the displaced cause stays pending. The core acknowledges the shown vector, which clears that cause's flag, and the next winner follows. The controller never compares the level against the core's current mask, so a cause at level 0 is still presented.

Software reaches the block through a small word-addressed register port with combinational read data:

- Word 0 is the enable register: bit i enables cause i.
- Word 1 is the flag register: bit i reads the pending flag of cause i, and writing 1 to a bit clears that flag.
- Words 2 onward are the level words, each holding the levels of two causes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every enable bit, pending flag and level field is 0, and irq_req, irq_vec and irq_lvl are 0.
- R2: Level word 2+k holds the level of cause 2k in bits 2:0 and that of cause 2k+1 in bits 10:8. Bits 7:3 and 15:11 ignore writes and read as 0.
- R3: Word 0 bit i is the enable of cause i, readable and writable. Word 1 bit i reads the pending flag of cause i. Writes to bits at or above the cause count have no effect and read as 0.
- R4: A one-cycle pulse on src_pulse[i] sets flag i. Only causes that are flagged and enabled compete, so a pending but disabled cause is never presented.
- R5: Among competing causes, the one with the numerically highest level is presented on irq_vec and irq_lvl.
- R6: When competing causes share the highest level, the smallest cause number is presented.
- R7: If a higher-level cause arrives while a request is shown, irq_vec and irq_lvl switch to it. The displaced cause stays pending and is presented once the higher one is acknowledged.
- R8: A cause at level 0 is presented like any other; the block applies no level threshold of its own.
- R9: irq_ack while irq_req is high clears the flag of exactly the cause shown on irq_vec. From the next clock edge the outputs show the next winner.
- R10: Writing 1 to bit i of word 1 clears flag i. A source pulse in the same cycle as a software clear or an acknowledge of that cause keeps the flag set.
- R11: With no competing cause, irq_req is 0 and irq_vec and irq_lvl are 0.
- R12: A change of pending flags shows on the outputs after one clock edge. A write to the enable or level registers shows after two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | N_SRC | One-cycle set pulses, one per cause |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq_ack | input | 1 | Core acknowledge of the shown vector |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VW | Vector number of the presented cause |
| irq_lvl | output | LVL_W | Level of the presented cause |

## Verification
The bench sweeps all 64 level pairs for one even and one odd cause. A layout that swapped the two fields, or a tie rule that favoured the higher number, would present the wrong vector. It also drains many pseudo-random pending sets one acknowledge at a time. An acknowledge that cleared the wrong flag, or dropped a displaced cause, would break the expected order or end the drain early. Pulses that land on the same cycle as a clear or an acknowledge catch a design that lets the clear win. The bench samples one and two edges after enable writes, which would expose extra or missing pipeline stages.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
   localparam int unsigned REG_W         = 16;
   localparam int unsigned WORD_ENABLE   = 0;
   localparam int unsigned WORD_FLAG     = 1;
   localparam int unsigned WORD_LVL_BASE = 2;
   localparam int unsigned ODD_FIELD_LSB = 8;
endpackage

// File: rtl/ipc_cfg_regs.sv
module ipc_cfg_regs
   import ipc_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned LVL_W = 3,
   parameter int unsigned AW    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [AW-1:0]          addr,
   input  logic [REG_W-1:0]       wdata,
   output logic [N_SRC-1:0]       en_q,
   output logic [N_SRC*LVL_W-1:0] lvl_flat,
   output logic [REG_W-1:0]       rdata
);
   localparam int unsigned N_WORDS = N_SRC / 2;

   logic [LVL_W-1:0] lvl_q [N_SRC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (we && addr == AW'(WORD_ENABLE))
         en_q <= wdata[N_SRC-1:0];
   end

   for (genvar k = 0; k < N_WORDS; k++) begin : g_lvl_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q[2*k]   <= '0;
            lvl_q[2*k+1] <= '0;
         end else if (we && addr == AW'(WORD_LVL_BASE + k)) begin
            lvl_q[2*k]   <= wdata[LVL_W-1:0];
            lvl_q[2*k+1] <= wdata[ODD_FIELD_LSB +: LVL_W];
         end
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_flat
      assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q[i];
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(WORD_ENABLE))
         rdata[N_SRC-1:0] = en_q;
      for (int k = 0; k < N_WORDS; k++) begin
         if (addr == AW'(WORD_LVL_BASE + k)) begin
            rdata[LVL_W-1:0]               = lvl_q[2*k];
            rdata[ODD_FIELD_LSB +: LVL_W]  = lvl_q[2*k+1];
         end
      end
   end
endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank #(
   parameter int unsigned N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flag_q,
   output logic [N_SRC-1:0] flag_d
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_flag
      // a set pulse outranks any clear in the same cycle
      assign flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= flag_d[i];
      end
   end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned LVL_W = 3,
   parameter int unsigned VW    = 3
) (
   input  logic [N_SRC-1:0]       cand,
   input  logic [N_SRC*LVL_W-1:0] lvl_flat,
   output logic                   any,
   output logic [VW-1:0]          win_vec,
   output logic [LVL_W-1:0]       win_lvl
);
   always_comb begin
      any     = 1'b0;
      win_vec = '0;
      win_lvl = '0;
      // ascending scan with strict compare keeps the lowest index on ties
      for (int i = 0; i < N_SRC; i++) begin
         if (cand[i] && (!any || lvl_flat[i*LVL_W +: LVL_W] > win_lvl)) begin
            any     = 1'b1;
            win_vec = VW'(i);
            win_lvl = lvl_flat[i*LVL_W +: LVL_W];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import ipc_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned LVL_W = 3,
   parameter int unsigned AW    = $clog2(WORD_LVL_BASE + N_SRC / 2),
   parameter int unsigned VW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_pulse,
   input  logic              reg_we,
   input  logic [AW-1:0]     reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [VW-1:0]     irq_vec,
   output logic [LVL_W-1:0]  irq_lvl
);
   if (N_SRC < 2 || N_SRC > REG_W || (N_SRC % 2) != 0) begin : g_bad_nsrc
      $error("N_SRC must be even and between 2 and 16");
   end
   if (LVL_W < 1 || LVL_W > ODD_FIELD_LSB) begin : g_bad_lvlw
      $error("LVL_W must be between 1 and 8");
   end
   if ((1 << AW) < WORD_LVL_BASE + N_SRC / 2) begin : g_bad_aw
      $error("AW too narrow for the register map");
   end

   logic [N_SRC-1:0]       en_q;
   logic [N_SRC*LVL_W-1:0] lvl_flat;
   logic [REG_W-1:0]       cfg_rdata;
   logic [N_SRC-1:0]       flag_q, flag_d;
   logic [N_SRC-1:0]       sw_clr, ack_clr;
   logic                   any;
   logic [VW-1:0]          win_vec;
   logic [LVL_W-1:0]       win_lvl;

   ipc_cfg_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W), .AW(AW)) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .en_q     (en_q),
      .lvl_flat (lvl_flat),
      .rdata    (cfg_rdata)
   );

   assign sw_clr = (reg_we && reg_addr == AW'(WORD_FLAG)) ? reg_wdata[N_SRC-1:0] : '0;

   always_comb begin
      ack_clr = '0;
      if (irq_ack && irq_req)
         ack_clr[irq_vec] = 1'b1;
   end

   ipc_flag_bank #(.N_SRC(N_SRC)) i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_pulse),
      .clr_i  (sw_clr | ack_clr),
      .flag_q (flag_q),
      .flag_d (flag_d)
   );

   ipc_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W), .VW(VW)) i_arb (
      .cand     (flag_d & en_q),
      .lvl_flat (lvl_flat),
      .any      (any),
      .win_vec  (win_vec),
      .win_lvl  (win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_vec <= '0;
         irq_lvl <= '0;
      end else begin
         irq_req <= any;
         irq_vec <= win_vec;
         irq_lvl <= win_lvl;
      end
   end

   always_comb begin
      reg_rdata = cfg_rdata;
      if (reg_addr == AW'(WORD_FLAG))
         reg_rdata[N_SRC-1:0] = flag_q;
   end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned LVL_W = 3,
   parameter int unsigned AW    = 3,
   parameter int unsigned VW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] src_pulse,
   input logic             irq_ack,
   input logic             irq_req,
   input logic [VW-1:0]    irq_vec,
   input logic [LVL_W-1:0] irq_lvl,
   input logic [N_SRC-1:0] flag_q,
   input logic [N_SRC-1:0] en_q,
   input logic [AW-1:0]    reg_addr,
   input logic [15:0]      reg_rdata
);
   localparam logic [15:0] FIELD_MASK = 16'((1 << LVL_W) - 1);
   localparam logic [15:0] RSV_MASK   = ~(FIELD_MASK | (FIELD_MASK << 8));

   logic [N_SRC-1:0] en_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_prev <= '0;
      else        en_prev <= en_q;
   end

   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == '0 && irq_lvl == '0));

   p_req_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> flag_q[irq_vec]);

   p_req_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> en_prev[irq_vec]);

   p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !src_pulse[irq_vec]) |=> !flag_q[$past(irq_vec)]);

   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr >= AW'(2)) |-> ((reg_rdata & RSV_MASK) == 16'h0));

   for (genvar i = 0; i < N_SRC; i++) begin : g_set
      p_pulse_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
         src_pulse[i] |=> flag_q[i]);
   end
endmodule

bind prio_irq_ctrl ipc_checker #(.N_SRC(N_SRC), .LVL_W(LVL_W), .AW(AW), .VW(VW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_pulse (src_pulse),
   .irq_ack   (irq_ack),
   .irq_req   (irq_req),
   .irq_vec   (irq_vec),
   .irq_lvl   (irq_lvl),
   .flag_q    (flag_q),
   .en_q      (en_q),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
   localparam int N  = 8;
   localparam int LW = 3;
   localparam int AW = 3;
   localparam int VW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_pulse = '0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          irq_ack = 1'b0;
   logic          irq_req;
   logic [VW-1:0] irq_vec;
   logic [LW-1:0] irq_lvl;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [N-1:0] m_flag = '0;
   logic [N-1:0] m_en   = '0;
   int           m_lvl [N];
   logic [15:0]  lfsr = 16'hACE1;

   always #10 clk = ~clk;

   prio_irq_ctrl #(.N_SRC(N), .LVL_W(LW)) i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl));

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // expected winner: maximise level*N + (N-1-index)
   task automatic check_out(string req);
      int best = -1;
      int bv = 0;
      int bl = 0;
      for (int i = 0; i < N; i++) begin
         if (m_flag[i] && m_en[i] && (m_lvl[i] * N + (N - 1 - i)) > best) begin
            best = m_lvl[i] * N + (N - 1 - i);
            bv = i;
            bl = m_lvl[i];
         end
      end
      check({req, " req"}, int'(irq_req), best >= 0 ? 1 : 0);
      check({req, " vec"}, int'(irq_vec), bv);
      check({req, " lvl"}, int'(irq_lvl), bl);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(int a, logic [15:0] d);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      step();
      reg_we = 1'b0;
      if (a == 0) m_en = d[N-1:0];
      else if (a == 1) m_flag = m_flag & ~d[N-1:0];
      else if (a >= 2 && a < 2 + N/2) begin
         m_lvl[2*(a-2)]   = int'(d[LW-1:0]);
         m_lvl[2*(a-2)+1] = int'(d[8 +: LW]);
      end
   endtask

   task automatic rd_check(string req, int a, int exp);
      reg_addr = AW'(a);
      #1;
      check(req, int'(reg_rdata), exp);
   endtask

   task automatic pulse(logic [N-1:0] m);
      src_pulse = m;
      step();
      src_pulse = '0;
      m_flag = m_flag | m;
   endtask

   task automatic ack();
      int v = int'(irq_vec);
      bit r = irq_req;
      irq_ack = 1'b1;
      step();
      irq_ack = 1'b0;
      if (r) m_flag[v] = 1'b0;
   endtask

   task automatic set_lvl(int c, int l);
      int w = 2 + c / 2;
      logic [15:0] d;
      d = 16'(m_lvl[(c/2)*2]) | (16'(m_lvl[(c/2)*2+1]) << 8);
      if (c % 2 == 0) d[LW-1:0] = LW'(l);
      else            d[8 +: LW] = LW'(l);
      wr(w, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_lvl[i] = 0;
      step(); step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      check_out("R1");
      for (int a = 0; a < 2 + N/2; a++) rd_check("R1 regs", a, 0);

      // R2 layout and reserved bits
      for (int k = 0; k < N/2; k++) begin
         wr(2 + k, 16'hFFFF);
         rd_check("R2 all-ones", 2 + k, 16'h0707);
         wr(2 + k, 16'(((k + 1) & 7) | (((6 - k) & 7) << 8) | 16'hF8F8));
         rd_check("R2 fields", 2 + k, ((k + 1) & 7) | (((6 - k) & 7) << 8));
      end
      for (int k = 0; k < N/2; k++) wr(2 + k, 16'h0000);

      // R3 enable register
      wr(0, 16'hFFA5);
      rd_check("R3 enable", 0, 16'h00A5);
      wr(0, 16'h0000);

      // R4 disabled causes pend but are not presented
      pulse(8'hFF);
      rd_check("R4 flags", 1, 16'h00FF);
      step();
      check_out("R4 disabled");
      check("R4 disabled none", int'(irq_req), 0);
      wr(1, 16'hFFFF);
      rd_check("R10 w1c", 1, 0);

      // R5 R6 R8 sweep of levels for causes 2 and 5
      wr(0, 16'h00FF);
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            wr(3, 16'(a));
            wr(4, 16'(b << 8));
            pulse(8'b0010_0100);
            check_out(a == b ? "R6 tie" : (a == 0 || b == 0 ? "R8 level0" : "R5 highest"));
            check("R5 winner", int'(irq_vec), b > a ? 5 : 2);
            wr(1, 16'h00FF);
            check_out("R11 idle");
         end
      end

      // R12 enable write latency
      wr(3, 16'h0000); wr(4, 16'h0000);
      wr(0, 16'h0000);
      pulse(8'b0000_1000);
      reg_we = 1'b1; reg_addr = 0; reg_wdata = 16'h0008;
      step();
      reg_we = 1'b0; m_en = 8'h08;
      check("R12 one edge", int'(irq_req), 0);
      step();
      check("R12 two edges", int'(irq_req), 1);
      check("R12 vec", int'(irq_vec), 3);
      wr(1, 16'h00FF);
      wr(0, 16'h00FF);

      // R7 preemption
      set_lvl(6, 1);
      set_lvl(1, 5);
      step();
      pulse(8'b0100_0000);
      check_out("R7 first");
      check("R7 first vec", int'(irq_vec), 6);
      pulse(8'b0000_0010);
      check_out("R7 preempt");
      check("R7 preempt vec", int'(irq_vec), 1);
      ack();
      check_out("R7 displaced");
      check("R7 displaced vec", int'(irq_vec), 6);
      ack();
      check_out("R9 drained");

      // R10 set beats software clear, set beats ack
      pulse(8'b0100_0000);
      src_pulse = 8'b0100_0000; reg_we = 1'b1; reg_addr = 1; reg_wdata = 16'h0040;
      step();
      src_pulse = '0; reg_we = 1'b0;
      rd_check("R10 set over clear", 1, 16'h0040);
      src_pulse = 8'b0100_0000; irq_ack = 1'b1;
      step();
      src_pulse = '0; irq_ack = 1'b0;
      check_out("R10 set over ack");
      check("R10 set over ack req", int'(irq_req), 1);
      ack();
      check_out("R11 empty");

      // R9 drains of pseudo-random configurations
      for (int r = 0; r < 40; r++) begin
         for (int c = 0; c < N; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            set_lvl(c, int'(lfsr[2:0]));
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         wr(0, 16'(lfsr[7:0] | 8'h11));
         step();
         pulse(lfsr[15:8]);
         check_out("R9 start");
         for (int k = 0; k < N + 1; k++) begin
            if (irq_req) begin
               ack();
               check_out("R9 next");
            end
         end
         check("R9 drained", int'(irq_req), 0);
         wr(1, 16'h00FF);
         check_out("R11 cleared");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule